// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Bank

This block holds the digital side of a four-channel, 12-bit parallel-input voltage converter. Each channel has two registers: a staging (input) register and a live (output) register. The live registers feed the downstream converters through one flat output vector. A host writes a channel's staging register over a 12-bit data bus, using two channel-select bits, a read/write level, an active-low select and an active-low load strobe.

The load strobe has two uses. When it is low during a selected write, the addressed channel's staging and live registers both take the data. When it is low while the select is high, all four live registers copy their staging registers in the same cycle. Readback returns the addressed staging register, not the live register.

The bus controls arrive asynchronously. They are sampled with the system clock through a two-stage synchronizer before they are decoded. The bidirectional bus is modelled as separate in and out ports plus an output enable. An active-low clear works independently of the select and forces every register to a code set by a parameter.

Top module: `quad_dac_regbank`

## Requirements
- R1: Channel-select value 0, 1, 2 and 3 address channels A to D. Channel k's live register appears on `ch_code[12*k +: 12]`, with bit 11 of each code as the MSB.
- R2: While `cs_n` is high, no staging register is written, whatever `rw`, `addr` and `din` are, and `dout_oe` stays low.
- R3: A selected write (`cs_n`=0, `rw`=0) with `ld_n`=1 writes `din` to the addressed staging register only. All live registers hold.
- R4: A selected write with `ld_n`=0 writes `din` to both the staging and the live register of the addressed channel. The other channels hold.
- R5: A selected read (`cs_n`=0, `rw`=1) drives the addressed channel's staging register on `dout` with `dout_oe`=1. It changes no register.
- R6: With `cs_n`=1 and `ld_n`=0, all four live registers copy their staging registers together.
- R7: `rst_n`=0 immediately sets every staging and live register to `RESET_CODE`, regardless of `cs_n`. This takes priority over any write or load in progress.
- R8: Whenever no selected read is decoded, `dout_oe` is 0 and `dout` is 0.
- R9: Inputs pass two synchronizer stages. An input pattern held from before rising edge n takes effect on rising edge n+2, and edge n+1 shows no change yet.
- R10: A selected read with `ld_n`=0 is still only a read. No live register is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Active-low clear to the reset code, asynchronous assert |
| cs_n | input | 1 | Active-low select enabling channel decode |
| rw | input | 1 | 1 = read back, 0 = write |
| ld_n | input | 1 | Active-low load strobe for the live registers |
| addr | input | 2 | Channel select |
| din | input | 12 | Bus data in |
| dout | output | 12 | Bus data out, 0 when released |
| dout_oe | output | 1 | Bus drive enable |
| ch_code | output | 48 | Four live-register codes, channel A in the low bits |

## Verification
Two functions can land in the same decoded cycle. In a transparent write, the staging and live registers of one channel take the same bus word together. A clear can also arrive while a write is still moving through the synchronizer. The bench applies a transparent write and pulls the clear low one edge later, before the write has been decoded. It then checks that every channel shows the reset code at once and that the pending write never lands. Random mixes of staged writes, transparent writes, load-all and reads are judged channel by channel against a two-bank reference model.

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int W = 12,
  parameter int CH = 4,
  parameter int SYNC = 2,
  parameter logic [W-1:0] RESET_CODE = W'(1) << (W-1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             ld_n,
  input  logic [$clog2(CH)-1:0] addr,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic             dout_oe,
  output logic [CH*W-1:0]  ch_code
);
  localparam int AW = $clog2(CH);
  localparam int SW = 3 + AW + W;
  localparam logic [SW-1:0] IDLE = {3'b111, {(AW+W){1'b0}}};

  logic [SYNC-1:0][SW-1:0] pipe;
  logic [SW-1:0] s;
  logic s_cs_n, s_rw, s_ld_n;
  logic [AW-1:0] s_addr;
  logic [W-1:0] s_din;
  logic sel, wr, rd, ld, ld_all;
  logic [CH-1:0][W-1:0] in_q, out_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= {SYNC{IDLE}};
    else        pipe <= {pipe[SYNC-2:0], {cs_n, rw, ld_n, addr, din}};

  assign s = pipe[SYNC-1];
  assign {s_cs_n, s_rw, s_ld_n, s_addr, s_din} = s;

  assign sel    = !s_cs_n;
  assign wr     = sel && !s_rw;
  assign rd     = sel && s_rw;
  assign ld     = !s_ld_n;
  assign ld_all = !sel && ld;

  for (genvar k = 0; k < CH; k++) begin : g_ch
    logic hit;
    assign hit = wr && (s_addr == AW'(k));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   in_q[k] <= RESET_CODE;
      else if (hit) in_q[k] <= s_din;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          out_q[k] <= RESET_CODE;
      else if (hit && ld)  out_q[k] <= s_din;
      else if (ld_all)     out_q[k] <= in_q[k];
  end

  assign ch_code = out_q;
  assign dout_oe = rd;
  assign dout    = rd ? in_q[s_addr] : '0;

  // R2
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(in_q));
  // R3
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ld) |=> $stable(out_q));
  // R4
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ld) |=> (out_q[$past(s_addr)] == $past(s_din)) && (in_q[$past(s_addr)] == $past(s_din)));
  // R5
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(in_q) && $stable(out_q));
  // R6
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_all |=> out_q == $past(in_q));
endmodule

// File: tb/quad_dac_regbank_bench.sv
module quad_dac_regbank_bench;
  localparam logic [11:0] RC = 12'h800;
  logic clk = 0, rst_n = 0, cs_n = 1, rw = 1, ld_n = 1;
  logic [1:0] addr = 0;
  logic [11:0] din = 0, dout;
  logic dout_oe;
  logic [47:0] ch_code;
  logic [11:0] exp_in [4];
  logic [11:0] exp_out [4];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_dac_regbank #(.W(12), .CH(4), .SYNC(2), .RESET_CODE(RC)) u_quad_dac_regbank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .ch_code(ch_code));

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    for (int k = 0; k < 4; k++) check(req, ch_code[12*k +: 12], exp_out[k]);
  endtask

  task automatic drive(bit c, bit r, bit l, logic [1:0] a, logic [11:0] d);
    @(negedge clk);
    cs_n = c; rw = r; ld_n = l; addr = a; din = d;
  endtask

  task automatic settle;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_gap;
    drive(1, 1, 1, 0, 0);
    settle();
    check("R8 oe", {11'd0, dout_oe}, 12'd0);
    check("R8 dout", dout, 12'd0);
  endtask

  task automatic do_read(logic [1:0] a, bit l, string req);
    drive(0, 1, l, a, 12'hABC);
    settle();
    check({req, " oe"}, {11'd0, dout_oe}, 12'd1);
    check({req, " data"}, dout, exp_in[a]);
    check_outs(l ? "R5 outputs" : "R10 outputs");
    idle_gap();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin exp_in[k] = RC; exp_out[k] = RC; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outs("R7 reset state");
    check("R8 reset oe", {11'd0, dout_oe}, 12'd0);
    rst_n = 1;
    settle();

    // R1 / R4: distinct transparent writes per channel
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 0, 2'(k), 12'h111 * 12'(k + 1) + 12'h00F);
      exp_in[k] = 12'h111 * 12'(k + 1) + 12'h00F;
      exp_out[k] = exp_in[k];
      settle();
      check_outs("R1 R4 transparent");
      idle_gap();
    end

    // R9: latency of a transparent write
    drive(0, 0, 0, 2'd2, 12'h5A5);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_outs("R9 no early change");
    @(posedge clk);
    @(negedge clk);
    exp_in[2] = 12'h5A5; exp_out[2] = 12'h5A5;
    check_outs("R9 change on third edge");
    idle_gap();

    // R3 staged writes, then R5 reads of staging
    drive(0, 0, 1, 2'd0, 12'hFFF); settle(); exp_in[0] = 12'hFFF; check_outs("R3 hold"); idle_gap();
    drive(0, 0, 1, 2'd3, 12'h000); settle(); exp_in[3] = 12'h000; check_outs("R3 hold"); idle_gap();
    do_read(2'd0, 1, "R5");
    do_read(2'd3, 1, "R5");
    // R10: read with load low performs no load
    do_read(2'd0, 0, "R10");

    // R2: unselected write ignored, verified by readback
    drive(1, 0, 1, 2'd1, 12'h3C3); settle();
    check("R2 oe", {11'd0, dout_oe}, 12'd0);
    check_outs("R2 outputs");
    idle_gap();
    do_read(2'd1, 1, "R2 readback");

    // R6: load all
    drive(1, 1, 0, 2'd0, 12'h000); settle();
    for (int k = 0; k < 4; k++) exp_out[k] = exp_in[k];
    check_outs("R6 load all");
    idle_gap();

    // R7: reset during a pending transparent write
    drive(0, 0, 0, 2'd1, 12'h777);
    @(posedge clk);
    #3 rst_n = 0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin exp_in[k] = RC; exp_out[k] = RC; end
    check_outs("R7 async clear");
    check("R7 oe", {11'd0, dout_oe}, 12'd0);
    cs_n = 1; rw = 1; ld_n = 1;
    @(negedge clk);
    rst_n = 1;
    settle();
    check_outs("R7 write dropped");
    do_read(2'd1, 1, "R7 staging");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [1:0] a;
      logic [11:0] d;
      op = int'($urandom % 6);
      a = 2'($urandom);
      d = 12'($urandom);
      case (op)
        0: begin drive(0, 0, 1, a, d); settle(); exp_in[a] = d; check_outs("R3 random"); idle_gap(); end
        1: begin drive(0, 0, 0, a, d); settle(); exp_in[a] = d; exp_out[a] = d; check_outs("R4 random"); idle_gap(); end
        2: do_read(a, 1, "R5 random");
        3: begin drive(1, 1, 0, a, d); settle();
             for (int k = 0; k < 4; k++) exp_out[k] = exp_in[k];
             check_outs("R6 random"); idle_gap(); end
        4: begin drive(1, 0, 1, a, d); settle(); check_outs("R2 random"); idle_gap(); end
        default: do_read(a, 0, "R10 random");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule